// File: doc/BRIEF.md
# CAN Bit Timing Configuration Unit

This unit stores the bit-timing settings of a CAN controller and turns them into three timing pulses: a time-quantum tick, a sample-point strobe and an end-of-bit strobe. Software reaches it through a small word-wide write port and a combinational read port. There are three registers. The control register holds an initialisation flag and a configuration-change enable. The timing register holds the low prescaler bits, the jump width and both time segments. The prescaler-extension register holds the upper prescaler bits.

Software first sets both control flags. It then programs the timing and extension registers, and finally clears the initialisation flag. The bit clock starts running on the next cycle. A nominal bit is one synchronisation quantum, then the first time segment (propagation plus phase 1), then the second time segment (phase 2). The sample strobe marks the boundary between the two segments. A hard-sync input lets the surrounding protocol engine restart the bit at its synchronisation quantum. The jump width is only stored and passed on for use by resynchronisation logic outside this unit.

Top module: `can_bit_timing`

## Requirements
- R1: After reset, the control register reads 0x0001 (initialisation set, change enable clear), the timing register reads 0x1201, the extension register reads 0x0000, and no tick or strobe is asserted.
- R2: The control register at address 0 can be written at any time. Bit 0 is the initialisation flag and bit 6 is the configuration-change enable. All other bits read as zero.
- R3: The timing register at address 1 has the prescaler low field in bits 5:0, the jump width in bits 7:6, the first segment in bits 11:8 and the second segment in bits 14:12. Bit 15 reads as zero. A write takes effect only while bits 0 and 6 of the control register are both set.
- R4: The extension register at address 2 holds prescaler bits 9:6 in its bits 3:0. Bits 15:4 read as zero. It has the same write gating as R3.
- R5: A write to address 1 or 2 while either control flag is clear has no effect. The readback and the generated timing stay unchanged.
- R6: While initialisation is clear, the quantum tick is a one-cycle pulse every N clocks, where N = {extension, low field} + 1. N ranges from 1 to 1024.
- R7: A bit lasts 1 + T1 + T2 quanta, where T2 = second field + 1. The end-of-bit strobe coincides with the tick that closes the last quantum.
- R8: The sample strobe coincides with the tick that closes quantum number T1, counting the synchronisation quantum as number 0. T1 = first field + 1.
- R9: A first-segment field of 0 is treated as 1, so the first segment never lasts less than 2 quanta.
- R10: While initialisation is set, no tick or strobe occurs and the counters are held. In the cycle after the edge that clears initialisation, the synchronisation quantum of a new bit begins.
- R11: A hard-sync pulse while running suppresses the tick in its own cycle. The next cycle starts a new bit at the synchronisation quantum with the prescaler restarted.
- R12: A write to address 3 has no effect and address 3 reads zero. The stored jump-width field is presented on its own output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Write address |
| wr_data | input | 16 | Write data |
| rd_addr | input | 2 | Read address |
| rd_data | output | 16 | Read data for rd_addr |
| hard_sync | input | 1 | Restart the bit at its synchronisation quantum |
| tq_tick | output | 1 | Pulse at the end of every time quantum |
| sample_stb | output | 1 | Pulse at the sample point |
| bit_end_stb | output | 1 | Pulse at the end of the nominal bit |
| sjw_out | output | 2 | Stored jump-width field |

## Verification
The bench covers the prescaler extremes: a divide factor of 1, where the tick fires every cycle, and a divide factor of 1024, which uses all ten prescaler bits. A design that dropped the extension bits, or placed them at the wrong position, would tick far too early. Timing-register writes made with only one of the two control flags set must be rejected. Likewise, writes made during operation must leave both the readback and the strobe positions unchanged. A design that gated on a single flag would silently retime the bit. A zero first-segment field must still produce a 2-quantum segment, or the sample point would land one quantum early. The bench checks that restarting through the initialisation flag and through hard sync both place the first tick exactly one divide period later. An off-by-one in the restart would shift every later strobe by one cycle.

// File: rtl/can_bt_pkg.sv
package can_bt_pkg;

    localparam int DATA_W = 16;
    localparam int ADDR_W = 2;
    localparam int BRP_W  = 6;
    localparam int EXT_W  = 4;
    localparam int SJW_W  = 2;
    localparam int TS1_W  = 4;
    localparam int TS2_W  = 3;

    // derived sizes
    localparam int PRE_W  = BRP_W + EXT_W;
    localparam int MAX_NQ = 1 + (1 << TS1_W) + (1 << TS2_W);
    localparam int QC_W   = $clog2(MAX_NQ);

    // register addresses
    localparam logic [ADDR_W-1:0] A_CTRL   = 2'd0;
    localparam logic [ADDR_W-1:0] A_TIMING = 2'd1;
    localparam logic [ADDR_W-1:0] A_PREEXT = 2'd2;

    // control bit positions, decoded by software
    localparam int INIT_BIT = 0;
    localparam int CCE_BIT  = 6;

    typedef struct packed {
        logic [TS2_W-1:0] tseg2;
        logic [TS1_W-1:0] tseg1;
        logic [SJW_W-1:0] sjw;
        logic [BRP_W-1:0] brp;
    } timing_t;

    localparam int TIMING_W = $bits(timing_t);

    localparam timing_t TIMING_RST = '{tseg2: 3'd1, tseg1: 4'd2, sjw: 2'd0, brp: 6'd1};

    typedef struct packed {
        logic init;
        logic cce;
    } ctrl_t;

    typedef struct packed {
        logic tick;
        logic sample;
        logic bit_end;
    } strobe_t;

    // full prescaler field (divide factor minus one)
    function automatic logic [PRE_W-1:0] divide_m1(input timing_t t, input logic [EXT_W-1:0] e);
        return {e, t.brp};
    endfunction

    // first segment length in quanta, never below two
    function automatic logic [QC_W-1:0] tseg1_quanta(input logic [TS1_W-1:0] f);
        if (f == '0)
            return QC_W'(2);
        return QC_W'(f) + QC_W'(1);
    endfunction

    // second segment length in quanta
    function automatic logic [QC_W-1:0] tseg2_quanta(input logic [TS2_W-1:0] f);
        return QC_W'(f) + QC_W'(1);
    endfunction

endpackage

// File: rtl/cbt_regs.sv
module cbt_regs
    import can_bt_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [DATA_W-1:0] rd_data,
    output ctrl_t             ctrl,
    output timing_t           timing,
    output logic [EXT_W-1:0]  pre_ext
);

    logic cfg_open;
    assign cfg_open = ctrl.init && ctrl.cce;

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl    <= '{init: 1'b1, cce: 1'b0};
            timing  <= TIMING_RST;
            pre_ext <= '0;
        end else if (wr_en) begin
            case (wr_addr)
                A_CTRL: begin
                    ctrl <= '{init: wr_data[INIT_BIT], cce: wr_data[CCE_BIT]};
                end
                A_TIMING: begin
                    if (cfg_open)
                        timing <= timing_t'(wr_data[TIMING_W-1:0]);
                end
                A_PREEXT: begin
                    if (cfg_open)
                        pre_ext <= wr_data[EXT_W-1:0];
                end
                default: ;
            endcase
        end
    end

    always_comb begin
        rd_data = '0;
        case (rd_addr)
            A_CTRL: begin
                rd_data[INIT_BIT] = ctrl.init;
                rd_data[CCE_BIT]  = ctrl.cce;
            end
            A_TIMING: rd_data[TIMING_W-1:0] = timing;
            A_PREEXT: rd_data[EXT_W-1:0]    = pre_ext;
            default:  rd_data = '0;
        endcase
    end

    logic unused_wr_bits;
    assign unused_wr_bits = ^wr_data[DATA_W-1:TIMING_W];

endmodule

// File: rtl/cbt_prescaler.sv
module cbt_prescaler #(
    parameter int W = 10
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         run,
    input  logic         restart,
    input  logic [W-1:0] div_m1,
    output logic         tick
);

    logic [W-1:0] cnt;
    logic         at_end;

    assign at_end = (cnt == div_m1);

    always_ff @(posedge clk) begin
        if (rst || !run || restart)
            cnt <= '0;
        else if (at_end)
            cnt <= '0;
        else
            cnt <= cnt + 1'b1;
    end

    assign tick = run && !restart && at_end;

endmodule

// File: rtl/cbt_quanta.sv
module cbt_quanta #(
    parameter int W = 5
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         run,
    input  logic         restart,
    input  logic         tick,
    input  logic [W-1:0] t1q,
    input  logic [W-1:0] last,
    output logic         sample,
    output logic         bit_end
);

    logic [W-1:0] qidx;

    always_ff @(posedge clk) begin
        if (rst || !run || restart)
            qidx <= '0;
        else if (tick)
            qidx <= (qidx == last) ? '0 : qidx + 1'b1;
    end

    assign sample  = tick && (qidx == t1q);
    assign bit_end = tick && (qidx == last);

endmodule

// File: rtl/can_bit_timing.sv
module can_bit_timing
    import can_bt_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [DATA_W-1:0] rd_data,
    input  logic              hard_sync,
    output logic              tq_tick,
    output logic              sample_stb,
    output logic              bit_end_stb,
    output logic [SJW_W-1:0]  sjw_out
);

    ctrl_t            ctrl;
    timing_t          timing;
    logic [EXT_W-1:0] pre_ext;
    logic             run;
    logic [PRE_W-1:0] div_m1;
    logic [QC_W-1:0]  t1q;
    logic [QC_W-1:0]  t2q;
    logic [QC_W-1:0]  last_q;
    strobe_t          stb;

    cbt_regs u_regs (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .wr_data (wr_data),
        .rd_addr (rd_addr),
        .rd_data (rd_data),
        .ctrl    (ctrl),
        .timing  (timing),
        .pre_ext (pre_ext)
    );

    assign run    = !ctrl.init;
    assign div_m1 = divide_m1(timing, pre_ext);
    assign t1q    = tseg1_quanta(timing.tseg1);
    assign t2q    = tseg2_quanta(timing.tseg2);
    assign last_q = t1q + t2q;

    cbt_prescaler #(.W(PRE_W)) u_pre (
        .clk     (clk),
        .rst     (rst),
        .run     (run),
        .restart (hard_sync),
        .div_m1  (div_m1),
        .tick    (stb.tick)
    );

    cbt_quanta #(.W(QC_W)) u_seq (
        .clk     (clk),
        .rst     (rst),
        .run     (run),
        .restart (hard_sync),
        .tick    (stb.tick),
        .t1q     (t1q),
        .last    (last_q),
        .sample  (stb.sample),
        .bit_end (stb.bit_end)
    );

    assign tq_tick     = stb.tick;
    assign sample_stb  = stb.sample;
    assign bit_end_stb = stb.bit_end;
    assign sjw_out     = timing.sjw;

endmodule

// File: rtl/cbt_checker.sv
module cbt_checker
    import can_bt_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              wr_en,
    input logic [ADDR_W-1:0] wr_addr,
    input logic [DATA_W-1:0] wr_data,
    input logic              hard_sync,
    input ctrl_t             ctrl,
    input timing_t           timing,
    input logic [EXT_W-1:0]  pre_ext,
    input logic              tq_tick,
    input logic              sample_stb,
    input logic              bit_end_stb
);

    assert_ctrl_write_R2: assert property (@(posedge clk) disable iff (rst)
        (wr_en && wr_addr == A_CTRL) |=>
            (ctrl.init == $past(wr_data[INIT_BIT]) && ctrl.cce == $past(wr_data[CCE_BIT])));

    assert_timing_gate_R5: assert property (@(posedge clk) disable iff (rst)
        (wr_en && wr_addr == A_TIMING && !(ctrl.init && ctrl.cce)) |=> $stable(timing));

    assert_ext_gate_R4: assert property (@(posedge clk) disable iff (rst)
        (wr_en && wr_addr == A_PREEXT && !(ctrl.init && ctrl.cce)) |=> $stable(pre_ext));

    assert_idle_init_R10: assert property (@(posedge clk) disable iff (rst)
        ctrl.init |-> !(tq_tick || sample_stb || bit_end_stb));

    assert_sample_on_tick_R8: assert property (@(posedge clk) disable iff (rst)
        sample_stb |-> (tq_tick && !bit_end_stb));

    assert_end_on_tick_R7: assert property (@(posedge clk) disable iff (rst)
        bit_end_stb |-> tq_tick);

    assert_hsync_restart_R11: assert property (@(posedge clk) disable iff (rst)
        hard_sync |=> !(sample_stb || bit_end_stb));

endmodule

bind can_bit_timing cbt_checker u_chk (
    .clk         (clk),
    .rst         (rst),
    .wr_en       (wr_en),
    .wr_addr     (wr_addr),
    .wr_data     (wr_data),
    .hard_sync   (hard_sync),
    .ctrl        (ctrl),
    .timing      (timing),
    .pre_ext     (pre_ext),
    .tq_tick     (tq_tick),
    .sample_stb  (sample_stb),
    .bit_end_stb (bit_end_stb)
);

// File: tb/can_bit_timing_test.sv
module can_bit_timing_test;

    // clock period of 4 time units (250 MHz at 1 ns per unit)
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        wr_en = 1'b0;
    logic [1:0]  wr_addr = '0;
    logic [15:0] wr_data = '0;
    logic [1:0]  rd_addr = '0;
    logic [15:0] rd_data;
    logic        hard_sync = 1'b0;
    logic        tq_tick, sample_stb, bit_end_stb;
    logic [1:0]  sjw_out;

    int n_checks = 0;
    int n_fail   = 0;
    int cyc      = 0;
    bit mon_on   = 1'b0;
    int seen     = 0;
    string mon_tag = "R6";

    typedef struct {
        int         cyc;
        logic [2:0] fl;   // {tick, sample, bit_end}
    } ev_t;
    ev_t exp_q[$];

    can_bit_timing uut (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .rd_addr(rd_addr), .rd_data(rd_data), .hard_sync(hard_sync),
        .tq_tick(tq_tick), .sample_stb(sample_stb), .bit_end_stb(bit_end_stb),
        .sjw_out(sjw_out)
    );

    always #2 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    task automatic check(input bit ok, input string req, input longint act, input longint expv);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, expv);
        end
    endtask

    // monitor: pops expected events and compares them with observed strobes
    always begin
        @(negedge clk);
        #1;
        if (mon_on && (tq_tick || sample_stb || bit_end_stb)) begin
            logic [2:0] obs;
            obs = {tq_tick, sample_stb, bit_end_stb};
            seen++;
            if (exp_q.size() == 0) begin
                check(1'b0, mon_tag, longint'(cyc) * 8 + obs, 0);
            end else begin
                ev_t e;
                string tg;
                e = exp_q.pop_front();
                if (e.fl[1] != obs[1])      tg = "R8";
                else if (e.fl[0] != obs[0]) tg = "R7";
                else                        tg = "R6";
                check(e.cyc == cyc && e.fl == obs, tg,
                      longint'(cyc) * 8 + obs, longint'(e.cyc) * 8 + e.fl);
            end
        end
    end

    task automatic wr(input logic [1:0] a, input logic [15:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd_chk(input logic [1:0] a, input logic [15:0] expv, input string req);
        @(negedge clk);
        rd_addr = a;
        #1;
        check(rd_data == expv, req, rd_data, expv);
    endtask

    // program timing with both control flags set, leaves initialisation set
    task automatic cfg(input int field10, input int sjw, input int t1f, input int t2f);
        logic [15:0] tv;
        tv = {1'b0, 3'(t2f), 4'(t1f), 2'(sjw), 6'(field10)};
        wr(2'd0, 16'h0041);
        wr(2'd1, tv);
        wr(2'd2, 16'(field10 >> 6));
    endtask

    // driver: start a bit (control write or hard sync), push expected events, wait
    task automatic run_bits(input int field10, input int t1f, input int t2f, input int nbits,
                            input bit use_hsync, input string req);
        int dv, t1q, t2q, nq, c, last;
        dv  = field10 + 1;
        t1q = ((t1f == 0) ? 1 : t1f) + 1;
        t2q = t2f + 1;
        nq  = 1 + t1q + t2q;
        @(negedge clk);
        mon_on = 1'b0;
        exp_q.delete();
        c = cyc;
        for (int q = 0; q < nbits * nq; q++) begin
            ev_t e;
            int qi;
            qi = q % nq;
            e.cyc = c + (q + 1) * dv;
            e.fl  = {1'b1, qi == t1q, qi == nq - 1};
            exp_q.push_back(e);
        end
        mon_tag = req;
        if (use_hsync) begin
            hard_sync = 1'b1;
        end else begin
            wr_en = 1'b1; wr_addr = 2'd0; wr_data = 16'h0000;
        end
        mon_on = 1'b1;
        @(negedge clk);
        hard_sync = 1'b0;
        wr_en = 1'b0;
        last = c + nbits * nq * dv;
        while (cyc < last + 1) @(negedge clk);
        mon_on = 1'b0;
        check(exp_q.size() == 0, req, exp_q.size(), 0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R1 reset state
        rd_chk(2'd0, 16'h0001, "R1");
        rd_chk(2'd1, 16'h1201, "R1");
        rd_chk(2'd2, 16'h0000, "R1");
        check(!(tq_tick || sample_stb || bit_end_stb), "R1", {tq_tick, sample_stb, bit_end_stb}, 0);

        // R2 control register field positions
        wr(2'd0, 16'hFFFF);
        rd_chk(2'd0, 16'h0041, "R2");

        // R3 / R4 field masks while configuration is open
        wr(2'd1, 16'hFFFF);
        rd_chk(2'd1, 16'h7FFF, "R3");
        wr(2'd2, 16'hFFFF);
        rd_chk(2'd2, 16'h000F, "R4");

        // R12 unused address
        wr(2'd3, 16'hFFFF);
        rd_chk(2'd3, 16'h0000, "R12");
        rd_chk(2'd1, 16'h7FFF, "R12");

        // R5 writes with only one flag set are dropped
        wr(2'd0, 16'h0001);
        wr(2'd1, 16'h1234);
        wr(2'd2, 16'h0003);
        rd_chk(2'd1, 16'h7FFF, "R5");
        rd_chk(2'd2, 16'h000F, "R5");
        wr(2'd0, 16'h0040);
        wr(2'd1, 16'h0000);
        rd_chk(2'd1, 16'h7FFF, "R5");
        wr(2'd0, 16'h0001);

        // R6 R7 R8 divide by 1: 1 + 3 + 2 quanta
        cfg(0, 2, 2, 1);
        @(negedge clk);
        check(sjw_out == 2'd2, "R12", sjw_out, 2);
        run_bits(0, 2, 1, 3, 1'b0, "R10");

        // R6 R7 R8 divide by 3: 1 + 6 + 4 quanta, restart by hard sync
        cfg(2, 1, 5, 3);
        run_bits(2, 5, 3, 2, 1'b0, "R7");
        run_bits(2, 5, 3, 2, 1'b1, "R11");

        // R4 extension bits: divide by 70
        cfg(69, 0, 1, 0);
        rd_chk(2'd2, 16'h0001, "R4");
        run_bits(69, 1, 0, 2, 1'b0, "R6");

        // R9 zero first-segment field behaves as two quanta
        cfg(1, 0, 0, 2);
        run_bits(1, 0, 2, 3, 1'b0, "R9");

        // R5 writes while running: readback and timing unchanged
        wr(2'd1, 16'h0000);
        wr(2'd2, 16'h000F);
        rd_chk(2'd1, 16'h2001, "R5");
        rd_chk(2'd2, 16'h0000, "R5");
        run_bits(1, 0, 2, 2, 1'b1, "R5");

        // R11 hard sync in the middle of a bit
        repeat (7) @(negedge clk);
        run_bits(1, 0, 2, 2, 1'b1, "R11");

        // R10 initialisation holds everything quiet
        wr(2'd0, 16'h0001);
        @(negedge clk);
        exp_q.delete();
        mon_tag = "R10";
        seen = 0;
        mon_on = 1'b1;
        repeat (60) @(negedge clk);
        mon_on = 1'b0;
        check(seen == 0, "R10", seen, 0);
        run_bits(1, 0, 2, 2, 1'b0, "R10");

        // R6 largest divide factor, 1024
        cfg(1023, 0, 1, 0);
        rd_chk(2'd1, 16'h013F, "R3");
        rd_chk(2'd2, 16'h000F, "R4");
        run_bits(1023, 1, 0, 1, 1'b0, "R6");

        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

endmodule